// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the host-facing register file of a single DMA channel. Software reaches it through a simple word-wide read/write port. It holds the command pointer, three condition-select words and a status word. The status word is owned by hardware, so software cannot write it directly. Software changes the run state only through a masked control write: the upper half of the written word says which control bits to touch and the lower half gives their new values. From the result of such a write the block derives whether the channel is active.

The descriptor sequencer is outside this block. It sees the status word, the pointer and the select words as outputs. It receives a one-cycle kick when a control write leaves the channel active, and a one-cycle flush request when software asks for a flush or when the channel is stopped or paused. The sequencer reports its own events back through dedicated inputs: a channel gone dead, ACTIVE dropped on a stop, a branch taken or cleared, and a flush finished.

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous active-low reset, every register (status, command pointer, all three select words) reads zero, and the flush_req, kick and rd_valid outputs are low.
- R2: A write to word 0 (control) treats wdata[31:16] as a per-bit mask and wdata[15:0] as values. Status bit positions are RUN 15, PAUSE 14, FLUSH 13, WAKE 12, DEAD 11, ACTIVE 10 and BT 8. A control bit whose mask bit is 0 keeps its value.
- R3: A control write with the RUN mask set and RUN value 1 sets RUN. With the RUN mask set and RUN value 0 it clears both RUN and DEAD.
- R4: A control write with the WAKE mask and value both 1 sets WAKE only when RUN (after this write's own RUN update) is 1.
- R5: When the PAUSE mask bit is 1, PAUSE takes the written PAUSE value, whether 0 or 1.
- R6: If a control write leaves PAUSE=1 or RUN=0, ACTIVE is cleared and flush_req pulses high for one cycle, in the cycle after the write.
- R7: Otherwise ACTIVE is set when the write's mask touched RUN or PAUSE, or when it wrote WAKE=1. In all other cases ACTIVE is unchanged.
- R8: A control write with the FLUSH mask and value both 1 pulses flush_req in the next cycle and sets the FLUSH status bit. FLUSH stays set until the hw_flush_done input clears it.
- R9: kick pulses high for one cycle, in the cycle after a control write, when the resulting status has ACTIVE=1.
- R10: The hardware inputs act in the same cycle and override the result of a control write:
  - hw_dead_set sets DEAD.
  - hw_active_clr clears ACTIVE, and kick then stays low.
  - hw_bt_set sets BT and hw_bt_clr clears it; clear wins if both are high.
  - hw_flush_done clears FLUSH, unless an explicit flush is written in the same cycle.
- R11: A write to word 2 (command pointer) is ignored while ACTIVE is 1. An accepted pointer has its low 4 bits forced to zero.
- R12: Reads return data one cycle after rd_en, with rd_valid high. The read map is:
  - Words 0 and 1 return the status word, zero-extended.
  - Word 2 returns the pointer.
  - Words 3, 4 and 5 return the interrupt, branch and wait select words.
  - Words 6 and 7 return zero.
  Writes to words 1, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (3) | Word index |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| hw_dead_set | input | 1 | Sequencer marks channel dead |
| hw_active_clr | input | 1 | Sequencer drops ACTIVE (stop) |
| hw_bt_set | input | 1 | Sequencer took a branch |
| hw_bt_clr | input | 1 | Sequencer clears branch-taken |
| hw_flush_done | input | 1 | Flush operation finished |
| status | output | DATA_W/2 (16) | Status word |
| cmd_ptr | output | DATA_W (32) | Aligned command pointer |
| sel_regs | output | 3*DATA_W (96) | Select words; interrupt in the low word, then branch, then wait |
| flush_req | output | 1 | One-cycle flush request to the sequencer |
| kick | output | 1 | One-cycle start request to the sequencer |

## Verification
The bench exercises the masked control write with several patterns:
- Values given with an all-zero mask, which separates "ignored" from "applied".
- WAKE written both with RUN clear and with RUN set, which shows whether the wake gate looks at RUN.
- PAUSE set and then cleared, which tells the forced-flush path from the activation path.
- An explicit flush on a running channel, which shows that flush_req can fire while ACTIVE is kept.

Hardware events are applied both alone and in the same cycle as a control write, which exposes the override order. The pointer is written while the channel is active and again while it is stopped, which covers both the lock and the alignment.

// File: rtl/dma_chan_pkg.sv
// Shared constants for the DMA channel register block.
// Assumes a 16-bit status word with control bits at fixed positions;
// the sequencer decodes the same positions.
package dma_chan_pkg;
    localparam int ST_BT     = 8;
    localparam int ST_ACTIVE = 10;
    localparam int ST_DEAD   = 11;
    localparam int ST_WAKE   = 12;
    localparam int ST_FLUSH  = 13;
    localparam int ST_PAUSE  = 14;
    localparam int ST_RUN    = 15;

    localparam int A_CTRL = 0;
    localparam int A_STAT = 1;
    localparam int A_CPTR = 2;
    localparam int A_SEL0 = 3;

    typedef struct packed {
        logic run;
        logic pause;
        logic flush;
        logic wake;
    } ctl_bits_t;
endpackage

// File: rtl/dma_chan_ctrl_decode.sv
// Combinational decoder for a masked control write.
// Produces the status word after software's update, plus the two flush
// causes. Assumes SW > 15 so that every control bit position exists.
module dma_chan_ctrl_decode
    import dma_chan_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic [SW-1:0] cur,
    input  ctl_bits_t     msk,
    input  ctl_bits_t     val,
    output logic [SW-1:0] nxt,
    output logic          force_flush,
    output logic          flush_cmd
);
    // Apply RUN, WAKE and PAUSE, then derive ACTIVE from the result.
    always_comb begin
        nxt         = cur;
        force_flush = 1'b0;
        if (msk.run) begin
            if (val.run) begin
                nxt[ST_RUN] = 1'b1;
            end else begin
                nxt[ST_RUN]  = 1'b0;
                nxt[ST_DEAD] = 1'b0;
            end
        end
        if (msk.wake && val.wake && nxt[ST_RUN]) begin
            nxt[ST_WAKE] = 1'b1;
        end
        if (msk.pause) begin
            nxt[ST_PAUSE] = val.pause;
        end
        if (nxt[ST_PAUSE] || !nxt[ST_RUN]) begin
            nxt[ST_ACTIVE] = 1'b0;
            force_flush    = 1'b1;
        end else if (msk.run || msk.pause || (msk.wake && val.wake)) begin
            nxt[ST_ACTIVE] = 1'b1;
        end
        flush_cmd = msk.flush && val.flush;
    end
endmodule

// File: rtl/dma_chan_status_reg.sv
// Status word register with the sequencer's event inputs.
// Hardware events override the control-write result of the same cycle.
// Flush and kick requests are registered one-cycle pulses.
module dma_chan_status_reg
    import dma_chan_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [SW-1:0] ctrl_nxt,
    input  logic          force_flush,
    input  logic          flush_cmd,
    input  logic          hw_dead_set,
    input  logic          hw_active_clr,
    input  logic          hw_bt_set,
    input  logic          hw_bt_clr,
    input  logic          hw_flush_done,
    output logic [SW-1:0] status,
    output logic          flush_req,
    output logic          kick
);
    logic [SW-1:0] merged;

    // Merge the software result with the hardware events.
    always_comb begin
        merged = ctrl_we ? ctrl_nxt : status;
        if (hw_dead_set)   merged[ST_DEAD]   = 1'b1;
        if (hw_active_clr) merged[ST_ACTIVE] = 1'b0;
        if (hw_bt_set)     merged[ST_BT]     = 1'b1;
        if (hw_bt_clr)     merged[ST_BT]     = 1'b0;
        if (hw_flush_done) merged[ST_FLUSH]  = 1'b0;
        if (ctrl_we && flush_cmd) merged[ST_FLUSH] = 1'b1;
    end

    // Hold status and issue the request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status    <= '0;
            flush_req <= 1'b0;
            kick      <= 1'b0;
        end else begin
            status    <= merged;
            flush_req <= ctrl_we && (force_flush || flush_cmd);
            kick      <= ctrl_we && merged[ST_ACTIVE];
        end
    end
endmodule

// File: rtl/dma_chan_cfg_regs.sv
// Command pointer and condition-select registers.
// The pointer is aligned to 2**ALIGN_BITS bytes and is locked while the
// caller asserts ptr_lock.
module dma_chan_cfg_regs #(
    parameter int DW         = 32,
    parameter int NUM_SEL    = 3,
    parameter int ALIGN_BITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ptr_we,
    input  logic                  ptr_lock,
    input  logic [NUM_SEL-1:0]    sel_we,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         cmd_ptr,
    output logic [NUM_SEL*DW-1:0] sel_flat
);
    // Accept an aligned pointer unless the channel is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ptr <= '0;
        end else if (ptr_we && !ptr_lock) begin
            cmd_ptr <= {wdata[DW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        // Store one select word as written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_flat[g*DW +: DW] <= '0;
            end else if (sel_we[g]) begin
                sel_flat[g*DW +: DW] <= wdata;
            end
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
// Top of the DMA channel register block: word-indexed bus decode,
// a registered read port, and the wiring of decoder, status and config.
// Assumes ADDR_W is wide enough for A_SEL0 + NUM_SEL words.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int NUM_SEL    = 3,
    parameter int ALIGN_BITS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic                      rd_valid,
    input  logic                      hw_dead_set,
    input  logic                      hw_active_clr,
    input  logic                      hw_bt_set,
    input  logic                      hw_bt_clr,
    input  logic                      hw_flush_done,
    output logic [DATA_W/2-1:0]       status,
    output logic [DATA_W-1:0]         cmd_ptr,
    output logic [NUM_SEL*DATA_W-1:0] sel_regs,
    output logic                      flush_req,
    output logic                      kick
);
    localparam int SW = DATA_W / 2;
    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] ADR_CPTR = ADDR_W'(A_CPTR);
    localparam logic [ADDR_W-1:0] ADR_SEL0 = ADDR_W'(A_SEL0);

    ctl_bits_t          msk, val;
    logic [SW-1:0]      ctrl_nxt;
    logic               force_flush, flush_cmd;
    logic               ctrl_we, ptr_we;
    logic [NUM_SEL-1:0] sel_we;
    logic [DATA_W-1:0]  rd_next;

    // Pick the control bits out of the mask and value halves.
    always_comb begin
        msk = '{run: wdata[SW+ST_RUN], pause: wdata[SW+ST_PAUSE],
                flush: wdata[SW+ST_FLUSH], wake: wdata[SW+ST_WAKE]};
        val = '{run: wdata[ST_RUN], pause: wdata[ST_PAUSE],
                flush: wdata[ST_FLUSH], wake: wdata[ST_WAKE]};
    end

    assign ctrl_we = wr_en && (addr == ADR_CTRL);
    assign ptr_we  = wr_en && (addr == ADR_CPTR);

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_selwe
        assign sel_we[g] = wr_en && (addr == ADR_SEL0 + ADDR_W'(g));
    end

    dma_chan_ctrl_decode #(.SW(SW)) u_dec (
        .cur(status), .msk(msk), .val(val), .nxt(ctrl_nxt),
        .force_flush(force_flush), .flush_cmd(flush_cmd)
    );

    dma_chan_status_reg #(.SW(SW)) u_stat (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_nxt(ctrl_nxt),
        .force_flush(force_flush), .flush_cmd(flush_cmd),
        .hw_dead_set(hw_dead_set), .hw_active_clr(hw_active_clr),
        .hw_bt_set(hw_bt_set), .hw_bt_clr(hw_bt_clr),
        .hw_flush_done(hw_flush_done),
        .status(status), .flush_req(flush_req), .kick(kick)
    );

    dma_chan_cfg_regs #(.DW(DATA_W), .NUM_SEL(NUM_SEL), .ALIGN_BITS(ALIGN_BITS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we),
        .ptr_lock(status[ST_ACTIVE]), .sel_we(sel_we), .wdata(wdata),
        .cmd_ptr(cmd_ptr), .sel_flat(sel_regs)
    );

    // Select the word addressed by a read.
    always_comb begin
        rd_next = '0;
        if (addr == ADR_CTRL || addr == ADR_STAT) begin
            rd_next = {{(DATA_W-SW){1'b0}}, status};
        end else if (addr == ADR_CPTR) begin
            rd_next = cmd_ptr;
        end else begin
            for (int i = 0; i < NUM_SEL; i++) begin
                if (addr == ADR_SEL0 + ADDR_W'(i)) rd_next = sel_regs[i*DATA_W +: DATA_W];
            end
        end
    end

    // Register the read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= rd_next;
        end
    end
endmodule

// File: rtl/dma_chan_regs_chk.sv
// Property checker for dma_chan_regs, attached by bind.
// Assumes the status bit positions of dma_chan_pkg.
module dma_chan_regs_chk
    import dma_chan_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          hw_dead_set,
    input logic [DW/2-1:0] status,
    input logic [DW-1:0] cmd_ptr,
    input logic          flush_req,
    input logic          kick,
    input logic          rd_valid
);
    localparam int SW = DW / 2;
    logic run_clear_wr;
    assign run_clear_wr = wr_en && (addr == AW'(A_CTRL)) && wdata[SW+ST_RUN] && !wdata[ST_RUN];

    AST_RUN_CLEAR_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_clear_wr && !hw_dead_set) |=> (!status[ST_RUN] && !status[ST_DEAD])); // R3
    AST_WAKE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_WAKE]) |-> status[ST_RUN]); // R4
    AST_ACTIVE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_ACTIVE] |-> (status[ST_RUN] && !status[ST_PAUSE])); // R6
    AST_STOP_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        run_clear_wr |=> flush_req); // R6
    AST_KICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> status[ST_ACTIVE]); // R9
    AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_CPTR) && status[ST_ACTIVE]) |=> $stable(cmd_ptr)); // R11
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R12
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .hw_dead_set(hw_dead_set), .status(status),
    .cmd_ptr(cmd_ptr), .flush_req(flush_req), .kick(kick), .rd_valid(rd_valid)
);

// File: tb/dma_chan_regs_test.sv
// Scoreboard bench for dma_chan_regs: read tasks queue expected words,
// a monitor compares them as read data returns.
module dma_chan_regs_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid;
    logic        hw_dead_set = 0, hw_active_clr = 0, hw_bt_set = 0, hw_bt_clr = 0, hw_flush_done = 0;
    logic [15:0] status;
    logic [31:0] cmd_ptr;
    logic [95:0] sel_regs;
    logic        flush_req, kick;

    int errors = 0, checks = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        got_fl, got_kk;

    dma_chan_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .hw_dead_set(hw_dead_set), .hw_active_clr(hw_active_clr),
        .hw_bt_set(hw_bt_set), .hw_bt_clr(hw_bt_clr), .hw_flush_done(hw_flush_done),
        .status(status), .cmd_ptr(cmd_ptr), .sel_regs(sel_regs),
        .flush_req(flush_req), .kick(kick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each returned read with the head of the scoreboard.
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected read data", rdata, 32'hx);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // ev bits: 0 dead_set, 1 active_clr, 2 bt_set, 3 bt_clr, 4 flush_done
    task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d, input logic [4:0] ev);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d;
        {hw_flush_done, hw_bt_clr, hw_bt_set, hw_active_clr, hw_dead_set} = ev;
        @(negedge clk);
        got_fl = flush_req; got_kk = kick;
        wr_en = 1'b0;
        {hw_flush_done, hw_bt_clr, hw_bt_clr, hw_bt_set, hw_active_clr, hw_dead_set} = '0;
    endtask

    task automatic ctl(input logic [31:0] d, input logic [4:0] ev, input logic efl,
                       input logic ekk, input logic [15:0] est, input string t);
        cyc(1'b1, 3'd0, d, ev);
        check({t, " flush_req"}, {31'd0, got_fl}, {31'd0, efl});
        check({t, " kick"}, {31'd0, got_kk}, {31'd0, ekk});
        rd(3'd1, {16'd0, est}, {t, " status"});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 flush_req at reset", {31'd0, flush_req}, 32'd0);
        check("R1 kick at reset", {31'd0, kick}, 32'd0);
        for (int i = 0; i < 8; i++) rd(3'(i), 32'd0, "R1 reset word");
        // R11 alignment, R12 map
        cyc(1'b1, 3'd2, 32'h1234_567F, 5'd0);
        rd(3'd2, 32'h1234_5670, "R11 aligned pointer");
        cyc(1'b1, 3'd3, 32'h000F_0005, 5'd0);
        cyc(1'b1, 3'd4, 32'hA5A5_0001, 5'd0);
        cyc(1'b1, 3'd5, 32'h0003_0002, 5'd0);
        rd(3'd3, 32'h000F_0005, "R12 interrupt select");
        rd(3'd4, 32'hA5A5_0001, "R12 branch select");
        rd(3'd5, 32'h0003_0002, "R12 wait select");
        cyc(1'b1, 3'd1, 32'hFFFF_FFFF, 5'd0);
        cyc(1'b1, 3'd7, 32'hFFFF_FFFF, 5'd0);
        rd(3'd1, 32'd0, "R12 status write ignored");
        rd(3'd7, 32'd0, "R12 unused word reads zero");
        // R4/R6 wake while stopped
        ctl(32'h1000_1000, 5'd0, 1'b1, 1'b0, 16'h0000, "R4 wake without run");
        // R3/R7/R9 start
        ctl(32'h8000_8000, 5'd0, 1'b0, 1'b1, 16'h8400, "R3 run set");
        rd(3'd0, 32'h0000_8400, "R12 control word reads status");
        cyc(1'b1, 3'd2, 32'hAAAA_AAA0, 5'd0);
        rd(3'd2, 32'h1234_5670, "R11 pointer locked while active");
        ctl(32'h0000_FFFF, 5'd0, 1'b0, 1'b1, 16'h8400, "R2 zero mask");
        // R10 hardware events
        cyc(1'b0, 3'd0, 32'd0, 5'b00010);
        rd(3'd1, 32'h0000_8000, "R10 active_clr");
        cyc(1'b0, 3'd0, 32'd0, 5'b00100);
        cyc(1'b0, 3'd0, 32'd0, 5'b00001);
        rd(3'd1, 32'h0000_8900, "R10 bt_set dead_set");
        ctl(32'h1000_1000, 5'd0, 1'b0, 1'b1, 16'h9D00, "R4 wake with run");
        ctl(32'h4000_4000, 5'd0, 1'b1, 1'b0, 16'hD900, "R5 R6 pause set");
        ctl(32'h4000_0000, 5'd0, 1'b0, 1'b1, 16'h9D00, "R5 R7 pause clear");
        ctl(32'h2000_2000, 5'd0, 1'b1, 1'b1, 16'hBD00, "R8 explicit flush");
        cyc(1'b0, 3'd0, 32'd0, 5'b10000);
        rd(3'd1, 32'h0000_9D00, "R8 flush_done clears FLUSH");
        cyc(1'b0, 3'd0, 32'd0, 5'b01000);
        rd(3'd1, 32'h0000_9C00, "R10 bt_clr");
        ctl(32'h8000_0000, 5'd0, 1'b1, 1'b0, 16'h1000, "R3 R6 run clear");
        cyc(1'b1, 3'd2, 32'hFFFF_FFFF, 5'd0);
        rd(3'd2, 32'hFFFF_FFF0, "R11 pointer accepted when idle");
        ctl(32'h8000_8000, 5'b00010, 1'b0, 1'b0, 16'h9000, "R10 active_clr beats write");
        ctl(32'h1000_1000, 5'd0, 1'b0, 1'b1, 16'h9400, "R7 wake activates");
        ctl(32'h8000_0000, 5'b00001, 1'b1, 1'b0, 16'h1800, "R10 dead_set beats run clear");
        repeat (4) @(negedge clk);
        check("R12 all reads returned", exp_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule